// File: doc/BRIEF.md
# Codec Serial Port Frame Controller

This block is the digital serial port of a voice-band codec. It moves one 16-bit word out and one 16-bit word in per frame, framed by an active-low frame sync. In master mode it makes the bit clock (half the system clock rate) and the frame sync itself. The frame lasts 256 bit clocks for small cascades and 512 bit clocks when more than four devices share the link. In slave mode it follows a bit clock and a frame sync supplied from outside, both synchronous to the system clock.

A delayed frame-sync output drops 16 bit clocks after the block's own frame begins. It lasts 16 bit clocks, so the next device in a chain gets the following slot. A hardware request adds a secondary frame half a frame period after the next primary frame. A flag output either shows whether the current interval is primary or secondary, or shows a fixed level held in a small control register. A power-down input stops the port and clears its counters but keeps the control register.

Top module: `ccs_serial_port`

## Requirements
- R1: In master mode `sclk_o` toggles on every system clock edge, starting high on the first edge after reset or power-down release. A frame is 256 bit clocks when `dev_cnt_i` is 4 or less and 512 bit clocks when `dev_cnt_i` is 5 or more.
- R2: The frame sync is low for exactly 16 bit clocks, starting at the first bit-clock rise of the frame. `dout_oe_o` is high exactly while the frame sync is low and low (high impedance) otherwise.
- R3: `dout_o` changes only at a rising bit-clock edge. It carries `tx_word_i`, as captured when the frame begins, most significant bit first.
- R4: `din_i` is sampled at each falling bit-clock edge inside the frame, most significant bit first. After the 16th bit, `rx_word_o` holds the word and `rx_valid_o` is high for one system clock cycle.
- R5: `fsd_o` goes low 16 bit clocks after the block's own frame begins and stays low for 16 bit clocks, in both modes.
- R6: A one-cycle `sec_req_i` pulse during a master frame adds a secondary frame in the next frame. It starts half a frame period (128 or 256 bit clocks) after that frame's start and behaves as R2 to R5 describe.
- R7: With `cfg_sel` = 0 (the reset value), `flag_o` is low from each primary frame start and high from each secondary frame start. With `cfg_sel` = 1, `flag_o` equals the stored `cfg_val`. A cycle with `cfg_we_i` high stores `cfg_sel_i` and `cfg_val_i`.
- R8: While `pwrdn_n` is low, `fs_o` and `fsd_o` are high, `sclk_o` and `dout_oe_o` are low, and any pending secondary request is dropped. The control register keeps its value. After release, the next system clock edge starts a new frame at bit 0.
- R9: Reset clears the control register to `cfg_sel` = 0 and `cfg_val` = 0, and leaves the port idle with `fs_o` high, `fsd_o` high and `dout_oe_o` low.
- R10: In slave mode `fs_o` stays high and `sclk_o` stays low. A frame begins at a rising `sclk_i` edge where `fs_i` is low after having been high, and all bit timing follows `sclk_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwrdn_n | input | 1 | Active-low power-down |
| master_i | input | 1 | 1 = master, 0 = slave |
| dev_cnt_i | input | 4 | Number of cascaded devices |
| sclk_i | input | 1 | Bit clock in (slave) |
| fs_i | input | 1 | Active-low frame sync in (slave) |
| sclk_o | output | 1 | Bit clock out (master) |
| fs_o | output | 1 | Active-low frame sync out (master) |
| fsd_o | output | 1 | Delayed active-low frame sync for the next device |
| din_i | input | 1 | Serial data in |
| dout_o | output | 1 | Serial data out |
| dout_oe_o | output | 1 | Output enable for dout (0 = high impedance) |
| tx_word_i | input | 16 | Word to transmit |
| rx_word_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | One-cycle pulse when rx_word_o updates |
| sec_req_i | input | 1 | Request for a secondary frame |
| cfg_we_i | input | 1 | Control register write strobe |
| cfg_sel_i | input | 1 | Flag source: 0 = interval, 1 = fixed value |
| cfg_val_i | input | 1 | Fixed flag value |
| flag_o | output | 1 | Communication flag |

## Verification
Master frames use cascade counts on both sides of the 4/5 boundary, so both frame lengths and both secondary-frame offsets are covered. Directed words with isolated end bits (0x8001) show that MSB-first ordering and bit alignment are correct. Random words, request patterns and cascade counts then mix primary-only frames with primary-plus-secondary frames. Power-down entered in the middle of a frame, with a control write made during it, shows that the counters restart while the register is kept. A later reset shows that the register returns to its default. A slave frame driven by the bench's own bit clock shows that timing follows the external clock and that the delayed sync still falls in the next slot.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
    typedef struct packed {
        logic sel;
        logic val;
    } ccs_cfg_t;

    localparam ccs_cfg_t CFG_RESET = '{sel: 1'b0, val: 1'b0};
endpackage

// File: rtl/ccs_bitclk.sv
module ccs_bitclk (
    input  logic clk,
    input  logic rst_n,
    input  logic pwrdn_n,
    input  logic master,
    input  logic sclk_i,
    output logic sclk_o,
    output logic rise_o,
    output logic fall_o
);
    typedef struct packed {
        logic ph;
        logic sin;
    } bck_t;

    bck_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.sin = sclk_i;
        s_d.ph  = master & pwrdn_n & ~s_q.ph;
        if (master) begin
            rise_o = pwrdn_n & ~s_q.ph;
            fall_o = pwrdn_n & s_q.ph;
        end else begin
            rise_o = pwrdn_n & sclk_i & ~s_q.sin;
            fall_o = pwrdn_n & ~sclk_i & s_q.sin;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign sclk_o = s_q.ph;
endmodule

// File: rtl/ccs_framer.sv
module ccs_framer #(
    parameter int WORD_W     = 16,
    parameter int RATIO_LO   = 256,
    parameter int RATIO_HI   = 512,
    parameter int CASC_LIMIT = 4,
    parameter int DEV_W      = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwrdn_n,
    input  logic             master,
    input  logic             rise,
    input  logic             fs_i,
    input  logic [DEV_W-1:0] dev_cnt,
    input  logic             sec_req,
    output logic             act_o,
    output logic             load_o,
    output logic             step_o,
    output logic             last_o,
    output logic             fsd_n_o,
    output logic             comm_o
);
    localparam int BW = $clog2(RATIO_HI);
    localparam int PW = $clog2(2 * WORD_W) + 1;
    localparam logic [PW-1:0] POS_WORD = PW'(WORD_W);
    localparam logic [PW-1:0] POS_END  = PW'(2 * WORD_W);
    localparam logic [BW:0]   WIN_LEN  = (BW+1)'(WORD_W);

    typedef struct packed {
        logic [BW-1:0] bcnt;
        logic          act;
        logic          pend;
        logic          sec;
        logic          comm;
        logic [PW-1:0] pos;
    } frm_t;

    localparam frm_t FRM_IDLE = '{bcnt: '1, act: 1'b0, pend: 1'b0,
                                  sec: 1'b0, comm: 1'b0, pos: POS_END};

    frm_t s_d, s_q;
    logic [BW-1:0] lim;
    logic [BW:0]   half;
    logic [BW:0]   b1;

    always_comb begin
        lim  = (dev_cnt > DEV_W'(CASC_LIMIT)) ? BW'(RATIO_HI - 1) : BW'(RATIO_LO - 1);
        half = ({1'b0, lim} + 1'b1) >> 1;
        s_d      = s_q;
        s_d.pend = s_q.pend | sec_req;
        b1       = '0;
        if (rise) begin
            if (master) begin
                s_d.bcnt = (s_q.bcnt >= lim) ? '0 : s_q.bcnt + 1'b1;
                if (s_d.bcnt == '0) begin
                    s_d.sec  = s_q.pend | sec_req;
                    s_d.pend = 1'b0;
                    s_d.comm = 1'b0;
                end
                b1 = {1'b0, s_d.bcnt};
                s_d.act = (b1 < WIN_LEN) ||
                          (s_d.sec && (b1 >= half) && (b1 < half + WIN_LEN));
                if (s_d.sec && (b1 == half)) s_d.comm = 1'b1;
            end else begin
                s_d.act = ~fs_i;
            end
            if (s_d.act && !s_q.act)  s_d.pos = '0;
            else if (s_q.pos < POS_END) s_d.pos = s_q.pos + 1'b1;
        end
        if (!pwrdn_n) s_d = FRM_IDLE;

        load_o = rise & s_d.act & ~s_q.act;
        step_o = rise & s_d.act & s_q.act & (s_d.pos < POS_WORD);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= FRM_IDLE;
        else        s_q <= s_d;
    end

    assign act_o   = s_q.act;
    assign last_o  = (s_q.pos == POS_WORD - 1'b1);
    assign fsd_n_o = !((s_q.pos >= POS_WORD) && (s_q.pos < POS_END));
    assign comm_o  = s_q.comm;
endmodule

// File: rtl/ccs_shifter.sv
module ccs_shifter #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_n,
    input  logic              load,
    input  logic              step,
    input  logic              fall,
    input  logic              act,
    input  logic              last,
    input  logic [WORD_W-1:0] tx_word,
    input  logic              din,
    output logic              dout,
    output logic [WORD_W-1:0] rx_word,
    output logic              rx_valid
);
    typedef struct packed {
        logic [WORD_W-1:0] tsh;
        logic              dout;
        logic [WORD_W-1:0] rsh;
        logic [WORD_W-1:0] rxw;
        logic              rxv;
    } shf_t;

    shf_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.rxv = 1'b0;
        if (load) begin
            s_d.dout = tx_word[WORD_W-1];
            s_d.tsh  = tx_word << 1;
        end else if (step) begin
            s_d.dout = s_q.tsh[WORD_W-1];
            s_d.tsh  = s_q.tsh << 1;
        end
        if (fall && act) begin
            s_d.rsh = {s_q.rsh[WORD_W-2:0], din};
            if (last) begin
                s_d.rxw = {s_q.rsh[WORD_W-2:0], din};
                s_d.rxv = 1'b1;
            end
        end
        if (!pwrdn_n) begin
            s_d.tsh  = '0;
            s_d.dout = 1'b0;
            s_d.rsh  = '0;
            s_d.rxv  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign dout     = s_q.dout;
    assign rx_word  = s_q.rxw;
    assign rx_valid = s_q.rxv;
endmodule

// File: rtl/ccs_serial_port.sv
module ccs_serial_port
    import ccs_pkg::*;
#(
    parameter int WORD_W     = 16,
    parameter int RATIO_LO   = 256,
    parameter int RATIO_HI   = 512,
    parameter int CASC_LIMIT = 4,
    parameter int DEV_W      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwrdn_n,
    input  logic              master_i,
    input  logic [DEV_W-1:0]  dev_cnt_i,
    input  logic              sclk_i,
    input  logic              fs_i,
    output logic              sclk_o,
    output logic              fs_o,
    output logic              fsd_o,
    input  logic              din_i,
    output logic              dout_o,
    output logic              dout_oe_o,
    input  logic [WORD_W-1:0] tx_word_i,
    output logic [WORD_W-1:0] rx_word_o,
    output logic              rx_valid_o,
    input  logic              sec_req_i,
    input  logic              cfg_we_i,
    input  logic              cfg_sel_i,
    input  logic              cfg_val_i,
    output logic              flag_o
);
    ccs_cfg_t cfg_d, cfg_q;
    logic rise, fall, act, load, step, last, comm;

    ccs_bitclk u_bitclk (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrdn_n (pwrdn_n),
        .master  (master_i),
        .sclk_i  (sclk_i),
        .sclk_o  (sclk_o),
        .rise_o  (rise),
        .fall_o  (fall)
    );

    ccs_framer #(
        .WORD_W     (WORD_W),
        .RATIO_LO   (RATIO_LO),
        .RATIO_HI   (RATIO_HI),
        .CASC_LIMIT (CASC_LIMIT),
        .DEV_W      (DEV_W)
    ) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .pwrdn_n (pwrdn_n),
        .master  (master_i),
        .rise    (rise),
        .fs_i    (fs_i),
        .dev_cnt (dev_cnt_i),
        .sec_req (sec_req_i),
        .act_o   (act),
        .load_o  (load),
        .step_o  (step),
        .last_o  (last),
        .fsd_n_o (fsd_o),
        .comm_o  (comm)
    );

    ccs_shifter #(.WORD_W(WORD_W)) u_shifter (
        .clk      (clk),
        .rst_n    (rst_n),
        .pwrdn_n  (pwrdn_n),
        .load     (load),
        .step     (step),
        .fall     (fall),
        .act      (act),
        .last     (last),
        .tx_word  (tx_word_i),
        .din      (din_i),
        .dout     (dout_o),
        .rx_word  (rx_word_o),
        .rx_valid (rx_valid_o)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we_i) begin
            cfg_d.sel = cfg_sel_i;
            cfg_d.val = cfg_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_RESET;
        else        cfg_q <= cfg_d;
    end

    assign fs_o      = master_i ? ~act : 1'b1;
    assign dout_oe_o = act;
    assign flag_o    = cfg_q.sel ? cfg_q.val : comm;
endmodule

// File: rtl/ccs_serial_port_chk.sv
module ccs_serial_port_chk (
    input logic clk,
    input logic rst_n,
    input logic pwrdn_n,
    input logic master_i,
    input logic sclk_o,
    input logic fs_o,
    input logic fsd_o,
    input logic dout_o,
    input logic dout_oe_o,
    input logic rx_valid_o,
    input logic cfg_we_i,
    input logic cfg_sel_i,
    input logic cfg_val_i,
    input logic flag_o
);
    assert_sclk_toggles_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && pwrdn_n && $past(pwrdn_n) && $past(rst_n)) |-> (sclk_o != $past(sclk_o)));

    assert_hiz_outside_frame_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && fs_o) |-> !dout_oe_o);

    assert_dout_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && pwrdn_n && $past(pwrdn_n) && $past(rst_n) && !$rose(sclk_o)) |-> $stable(dout_o));

    assert_rx_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid_o |=> !rx_valid_o);

    assert_fsd_after_fs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_i && $fell(fsd_o)) |-> fs_o);

    assert_flag_forced_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we_i && cfg_sel_i) |=> (flag_o == $past(cfg_val_i)));

    assert_pwrdn_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !pwrdn_n |=> (fs_o && fsd_o && !dout_oe_o && !sclk_o));

    assert_slave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !master_i |-> (fs_o && !sclk_o));
endmodule

bind ccs_serial_port ccs_serial_port_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwrdn_n    (pwrdn_n),
    .master_i   (master_i),
    .sclk_o     (sclk_o),
    .fs_o       (fs_o),
    .fsd_o      (fsd_o),
    .dout_o     (dout_o),
    .dout_oe_o  (dout_oe_o),
    .rx_valid_o (rx_valid_o),
    .cfg_we_i   (cfg_we_i),
    .cfg_sel_i  (cfg_sel_i),
    .cfg_val_i  (cfg_val_i),
    .flag_o     (flag_o)
);

// File: tb/tb_ccs_serial_port.sv
module tb_ccs_serial_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwrdn_n = 1'b1;
    logic        master_i = 1'b1;
    logic [3:0]  dev_cnt_i = 4'd2;
    logic        sclk_i = 1'b0;
    logic        fs_i = 1'b1;
    logic        sclk_o, fs_o, fsd_o, dout_o, dout_oe_o, rx_valid_o, flag_o;
    logic        din_i = 1'b0;
    logic [15:0] tx_word_i = '0;
    logic [15:0] rx_word_o;
    logic        sec_req_i = 1'b0;
    logic        cfg_we_i = 1'b0, cfg_sel_i = 1'b0, cfg_val_i = 1'b0;

    int total = 0;
    int fails = 0;
    bit done = 0;
    bit exp_sel = 0, exp_val = 0;

    always #5 clk = ~clk;

    ccs_serial_port dut (
        .clk(clk), .rst_n(rst_n), .pwrdn_n(pwrdn_n), .master_i(master_i),
        .dev_cnt_i(dev_cnt_i), .sclk_i(sclk_i), .fs_i(fs_i), .sclk_o(sclk_o),
        .fs_o(fs_o), .fsd_o(fsd_o), .din_i(din_i), .dout_o(dout_o),
        .dout_oe_o(dout_oe_o), .tx_word_i(tx_word_i), .rx_word_o(rx_word_o),
        .rx_valid_o(rx_valid_o), .sec_req_i(sec_req_i), .cfg_we_i(cfg_we_i),
        .cfg_sel_i(cfg_sel_i), .cfg_val_i(cfg_val_i), .flag_o(flag_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit exp_flag(input bit sec, input int n, input int half);
        return exp_sel ? exp_val : (sec && n >= half);
    endfunction

    // One master frame, entered at the negedge before its first bit-clock rise.
    task automatic master_frame(input logic [3:0] dev, input logic [15:0] tx,
                                input logic [15:0] rxa, input logic [15:0] rxb,
                                input bit req, input bit sec);
        int ratio = (dev > 4) ? 512 : 256;
        int half = ratio / 2;
        int e_clk = 0, e_fs = 0, e_oe = 0, e_dout = 0, e_fsd = 0, e_flag = 0, e_rx = 0, nrx = 0;
        tx_word_i = tx;
        for (int c = 0; c < 2 * ratio; c++) begin
            int n = c / 2;
            bit pw, sw, efs, efsd;
            if (c % 2 == 1) begin
                if (n < 16) din_i = rxa[15 - n];
                else if (sec && n >= half && n < half + 16) din_i = rxb[15 - (n - half)];
            end
            sec_req_i = req && (c == 10);
            @(posedge clk);
            @(negedge clk);
            if (c == 0) dev_cnt_i = dev;
            pw   = (n < 16);
            sw   = sec && n >= half && n < half + 16;
            efs  = !(pw || sw);
            efsd = !((n >= 16 && n < 32) || (sec && n >= half + 16 && n < half + 32));
            if (sclk_o !== (c % 2 == 0)) e_clk++;
            if (fs_o !== efs) e_fs++;
            if (dout_oe_o !== !efs) e_oe++;
            if (pw && dout_o !== tx[15 - n]) e_dout++;
            if (sw && dout_o !== tx[15 - (n - half)]) e_dout++;
            if (fsd_o !== efsd) e_fsd++;
            if (flag_o !== exp_flag(sec, n, half)) e_flag++;
            if (rx_valid_o) begin
                nrx++;
                if (c == 31) begin
                    if (rx_word_o !== rxa) e_rx++;
                end else if (sec && c == 2 * half + 31) begin
                    if (rx_word_o !== rxb) e_rx++;
                end else e_rx++;
            end
        end
        sec_req_i = 1'b0;
        chk(e_clk == 0, "R1 bit clock and frame length", e_clk, 0);
        chk(e_fs == 0, sec ? "R2/R6 frame sync windows" : "R2 frame sync window", e_fs, 0);
        chk(e_oe == 0, "R2 output enable", e_oe, 0);
        chk(e_dout == 0, "R3 data out bits", e_dout, 0);
        chk(e_fsd == 0, "R5 delayed frame sync", e_fsd, 0);
        chk(e_flag == 0, "R7 flag", e_flag, 0);
        chk(e_rx == 0 && nrx == (sec ? 2 : 1), "R4 receive words", nrx, sec ? 2 : 1);
    endtask

    task automatic slave_frame(input logic [15:0] tx, input logic [15:0] rx);
        int e_oe = 0, e_dout = 0, e_fsd = 0, e_quiet = 0, e_rx = 0;
        tx_word_i = tx;
        for (int n = 0; n < 34; n++) begin
            sclk_i = 1'b1;
            fs_i   = (n < 16) ? 1'b0 : 1'b1;
            din_i  = (n < 16) ? rx[15 - n] : 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (dout_oe_o !== (n < 16)) e_oe++;
            if (n < 16 && dout_o !== tx[15 - n]) e_dout++;
            if (fsd_o !== !(n >= 16 && n < 32)) e_fsd++;
            if (fs_o !== 1'b1 || sclk_o !== 1'b0) e_quiet++;
            sclk_i = 1'b0;
            @(posedge clk);
            @(negedge clk);
            if (n == 15) begin
                if (rx_valid_o !== 1'b1 || rx_word_o !== rx) e_rx++;
            end else if (rx_valid_o) e_rx++;
        end
        fs_i = 1'b1;
        chk(e_quiet == 0, "R10 slave master outputs idle", e_quiet, 0);
        chk(e_oe == 0, "R10 slave output enable follows fs_i", e_oe, 0);
        chk(e_dout == 0, "R3 slave data out", e_dout, 0);
        chk(e_fsd == 0, "R5 slave delayed frame sync", e_fsd, 0);
        chk(e_rx == 0, "R4 slave receive", e_rx, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++;
            fails++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        bit sec_next = 0;
        void'($urandom(32'd2718));
        repeat (3) @(negedge clk);
        chk(fs_o === 1'b1 && fsd_o === 1'b1 && dout_oe_o === 1'b0, "R9 reset idle", fs_o, 1);
        chk(flag_o === 1'b0 && rx_valid_o === 1'b0, "R9 reset flag default", flag_o, 0);
        rst_n = 1'b1;

        // directed: short cascade, then with a secondary frame
        master_frame(4'd2, 16'h8001, 16'hA5C3, 16'h0000, 1'b1, 1'b0);
        master_frame(4'd2, 16'h8001, 16'h3C5A, 16'hF00F, 1'b0, 1'b1);
        // long cascade, both sides of the ratio boundary
        master_frame(4'd7, 16'h1234, 16'h8001, 16'h0000, 1'b1, 1'b0);
        master_frame(4'd5, 16'hFFFE, 16'h7FFF, 16'hC001, 1'b0, 1'b1);
        master_frame(4'd4, 16'h0F0F, 16'h5555, 16'h0000, 1'b0, 1'b0);
        // random frames (R6 request followed by secondary frame)
        for (int i = 0; i < 5; i++) begin
            bit r = 1'($urandom % 2);
            master_frame(4'($urandom % 8), 16'($urandom), 16'($urandom), 16'($urandom), r, sec_next);
            sec_next = r;
        end

        // power-down mid-frame with a control write (R8, R7)
        master_frame(4'd3, 16'hC3A5, 16'h0101, 16'h0000, 1'b1, sec_next);
        repeat (40) @(negedge clk);
        pwrdn_n = 1'b0;
        @(negedge clk);
        cfg_we_i = 1'b1; cfg_sel_i = 1'b1; cfg_val_i = 1'b1;
        @(negedge clk);
        cfg_we_i = 1'b0; cfg_sel_i = 1'b0; cfg_val_i = 1'b0;
        exp_sel = 1; exp_val = 1;
        repeat (3) @(negedge clk);
        chk(fs_o === 1'b1 && fsd_o === 1'b1, "R8 power-down frame syncs high", fs_o, 1);
        chk(sclk_o === 1'b0 && dout_oe_o === 1'b0, "R8 power-down clock and data idle", sclk_o, 0);
        chk(flag_o === 1'b1, "R7 forced flag value", flag_o, 1);
        pwrdn_n = 1'b1;
        // pending request was dropped; restart at bit 0 with config kept
        master_frame(4'd3, 16'h6996, 16'hE7E7, 16'h0000, 1'b1, 1'b0);
        master_frame(4'd3, 16'h1001, 16'h2BAD, 16'hBEEF, 1'b0, 1'b1);

        // reset restores defaults (R9)
        rst_n = 1'b0;
        exp_sel = 0; exp_val = 0;
        repeat (2) @(negedge clk);
        chk(flag_o === 1'b0, "R9 reset clears control register", flag_o, 0);
        rst_n = 1'b1;
        master_frame(4'd1, 16'h5A5A, 16'h9009, 16'h0000, 1'b0, 1'b0);

        // slave mode (R10)
        rst_n = 1'b0;
        master_i = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        slave_frame(16'hB00C, 16'h4E21);
        slave_frame(16'($urandom), 16'h8001);

        done = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule